// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This block holds four independent 16-bit timer channels behind a small memory-mapped register interface with 16-bit data. A shared run register starts and halts each channel on its own. Each channel has these parts:

- a prescaler, with a selectable count edge;
- a free-running counter;
- four compare registers, any of which can be chosen to clear the counter;
- one output pin.

In PWM mode the pin starts each period at a programmed initial level. It changes on a match with compare register A and goes back to the initial level when the counter clears. The clear register therefore sets the period and register A sets the duty. The pin action field also sets the polarity. With no action on match, the pin holds a fixed level, which gives 0% and 100% output.

Software writes a register with a single-cycle `wr_en` pulse. Reads are combinational from `addr`. Writing the pin-control register moves the pin to its new initial level at once, even when the channel is stopped. This lets software park an output at a safe level before it reconfigures the channel.

Top module: `pwm_timer_unit`

## Requirements
- R1: The run register is at address 0x000; its bit n starts channel n and it reads back zero-extended. Channel n occupies 0x010 + 0x40·n upward. Its registers are at these local offsets: control 0x00, mode 0x04, pin control 0x08, interrupt-enable 0x0C, status 0x10, counter 0x14, and compare A/B/C/D at 0x18/0x1C/0x20/0x24. Every one of them reads back all 16 bits written.
- R2: Any other address reads as zero: 0x001–0x00F, offsets inside a channel window that hold no register, and addresses at or above 0x110.
- R3: A channel's counter advances only while its run bit is 1. It holds its value while the bit is 0, and channels run independently.
- R4: The prescaler code is control[1:0] = p. With the rising-edge setting, the counter advances once every 4^p clocks. The first advance comes 4^p clocks after the run bit is set.
- R5: Control[4:3] selects the count edge. 0 is rising. 1 is falling, which counts at the same rate shifted half a prescale period earlier. 2 or 3 is both edges, which counts at twice the rate (every clock when p = 0).
- R6: Control[7:5] selects the clear source: 1 = A, 2 = B, 5 = C, 6 = D. Any other code means no clear. On a count tick while the counter equals the selected register, the counter goes to 0. Without a clear source the counter wraps from 0xFFFF to 0.
- R7: In PWM mode (mode[1:0] = 2), the pin returns to its initial level on the tick where the clear occurs.
- R8: Pin control[2] is the initial level. Pin control[1:0] is the action on the tick where the counter equals A: 0 keep, 1 drive low, 2 drive high, 3 invert. With action 0 the pin never moves except on a pin-control write.
- R9: A write to pin control drives the pin to the written bit 2 on the next clock, whether the channel runs or not.
- R10: A counter write loads the counter directly. A compare A write made while running is used from the next tick on.
- R11: The interrupt-enable and status registers and mode bits [15:2] only store values. They do not change counting or the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 9 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| pwm_out | output | 4 | Pin output of each channel |

## Verification
The assertions assume that `addr` and `wdata` are stable and synchronous to `clk`, and that a write lasts exactly one cycle. The hold property excludes cycles that write the counter, because such a write legally changes a stopped counter. The fixed-level property takes for granted that the pin was last placed by a pin-control write. The stimulus drives inputs just after a rising edge and issues at most one write per cycle. It changes control and compare registers only while the channel is halted, except for the one deliberate compare A update. It reads and samples the pins only while the channels are stopped, so a check never spends a cycle on a running counter.

// File: rtl/pwm_timer_pkg.sv
// Shared constants and encodings for the PWM timer unit.
// Assumes a byte address map with 16-bit registers on 4-byte steps.
package pwm_timer_pkg;

    localparam int CH_BASE   = 16;
    localparam int CH_STRIDE = 64;
    localparam int LOC_W     = 6;

    localparam logic [LOC_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [LOC_W-1:0] OFS_MODE = 6'h04;
    localparam logic [LOC_W-1:0] OFS_PIN  = 6'h08;
    localparam logic [LOC_W-1:0] OFS_IEN  = 6'h0C;
    localparam logic [LOC_W-1:0] OFS_STS  = 6'h10;
    localparam logic [LOC_W-1:0] OFS_CNT  = 6'h14;
    localparam logic [LOC_W-1:0] OFS_CMPA = 6'h18;
    localparam int               NUM_CMP  = 4;

    localparam logic [1:0] MODE_PWM = 2'd2;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_BOTH  = 2'd2,
        EDGE_BOTH2 = 2'd3
    } edge_sel_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_FLIP = 2'd3
    } pin_act_e;

endpackage

// File: rtl/pwm_prescaler.sv
// Per-channel prescaler. It divides the clock by 4^code and emits count
// ticks on the rising edge, the falling edge or both edges of the divided clock.
// Assumes: when run is low the divider is held at zero, so every start
// begins on a fresh prescale period.
module pwm_prescaler #(
    parameter int CODE_W = 2,
    localparam int DIV_W = 2 * ((1 << CODE_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        edge_sel,
    output logic              tick
);
    import pwm_timer_pkg::*;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last_val;
    logic [DIV_W-1:0] half_val;
    logic             rise_ev;
    logic             fall_ev;

    // Terminal and mid-period values of the divider for the chosen ratio.
    always_comb begin
        last_val = DIV_W'((32'd1 << (2 * code)) - 32'd1);
        half_val = last_val >> 1;
        rise_ev  = run && (div_q == last_val);
        fall_ev  = run && (div_q == half_val);
    end

    // Select which divided-clock edges produce a count tick.
    always_comb begin
        case (edge_sel_e'(edge_sel))
            EDGE_RISE: tick = rise_ev;
            EDGE_FALL: tick = fall_ev;
            default:   tick = rise_ev | fall_ev;
        endcase
    end

    // Divider counter, cleared while halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            div_q <= '0;
        else if (div_q >= last_val)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pwm_channel.sv
// One timer channel: register file, counter with selectable clear source,
// compare-match pin logic and combinational read mux.
// Assumes: wr_en is already qualified by the channel window decode and
// loc_addr is the byte offset inside that window.
module pwm_channel #(
    parameter int DATA_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic                            wr_en,
    input  logic [pwm_timer_pkg::LOC_W-1:0] loc_addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic                            pin,
    output logic [DATA_W-1:0]               cnt_o,
    output logic [2:0]                      pin_cfg_o
);
    import pwm_timer_pkg::*;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] pcfg_q;
    logic [DATA_W-1:0] ien_q;
    logic [DATA_W-1:0] sts_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cmp_q [NUM_CMP];
    logic              pin_q;
    logic              tick;
    logic              clr_en;
    logic [DATA_W-1:0] clr_val;
    logic              clr_hit;
    logic              a_hit;
    logic              pwm_mode;

    pwm_prescaler #(.CODE_W(2)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .code     (ctrl_q[1:0]),
        .edge_sel (ctrl_q[4:3]),
        .tick     (tick)
    );

    // Plain storage registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            pcfg_q <= '0;
            ien_q  <= '0;
            sts_q  <= '0;
        end else if (wr_en) begin
            case (loc_addr)
                OFS_CTRL: ctrl_q <= wdata;
                OFS_MODE: mode_q <= wdata;
                OFS_PIN:  pcfg_q <= wdata;
                OFS_IEN:  ien_q  <= wdata;
                OFS_STS:  sts_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Compare registers, one per generated slot on consecutive 4-byte offsets.
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        localparam logic [LOC_W-1:0] SLOT_OFS = OFS_CMPA + LOC_W'(4 * i);
        // Load compare slot i on a write to its offset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_q[i] <= '0;
            else if (wr_en && loc_addr == SLOT_OFS)
                cmp_q[i] <= wdata;
        end
    end

    // Decode the counter-clear source and the match conditions.
    always_comb begin
        clr_en  = 1'b1;
        clr_val = '0;
        case (ctrl_q[7:5])
            3'd1:    clr_val = cmp_q[0];
            3'd2:    clr_val = cmp_q[1];
            3'd5:    clr_val = cmp_q[2];
            3'd6:    clr_val = cmp_q[3];
            default: clr_en  = 1'b0;
        endcase
        clr_hit  = clr_en && (cnt_q == clr_val);
        a_hit    = (cnt_q == cmp_q[0]);
        pwm_mode = (mode_q[1:0] == MODE_PWM);
    end

    // Counter: direct load from the bus, else count with clear on match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_en && loc_addr == OFS_CNT)
            cnt_q <= wdata;
        else if (tick)
            cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
    end

    // Output pin: pin-control write forces the initial level, then match actions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else if (wr_en && loc_addr == OFS_PIN)
            pin_q <= wdata[2];
        else if (tick) begin
            if (pwm_mode && clr_hit)
                pin_q <= pcfg_q[2];
            else if (a_hit) begin
                case (pin_act_e'(pcfg_q[1:0]))
                    ACT_LOW:  pin_q <= 1'b0;
                    ACT_HIGH: pin_q <= 1'b1;
                    ACT_FLIP: pin_q <= ~pin_q;
                    default:  pin_q <= pin_q;
                endcase
            end
        end
    end

    // Read mux over the channel's local offsets; holes read zero.
    always_comb begin
        case (loc_addr)
            OFS_CTRL:          rdata = ctrl_q;
            OFS_MODE:          rdata = mode_q;
            OFS_PIN:           rdata = pcfg_q;
            OFS_IEN:           rdata = ien_q;
            OFS_STS:           rdata = sts_q;
            OFS_CNT:           rdata = cnt_q;
            OFS_CMPA:          rdata = cmp_q[0];
            OFS_CMPA + 6'h04:  rdata = cmp_q[1];
            OFS_CMPA + 6'h08:  rdata = cmp_q[2];
            OFS_CMPA + 6'h0C:  rdata = cmp_q[3];
            default:           rdata = '0;
        endcase
    end

    assign pin       = pin_q;
    assign cnt_o     = cnt_q;
    assign pin_cfg_o = pcfg_q[2:0];

endmodule

// File: rtl/pwm_timer_unit.sv
// Four-channel compare-match PWM timer. It decodes the bus into the shared
// run register and the per-channel windows, and merges read data.
// Assumes: single-cycle write strobes, combinational reads, and an address
// range wide enough to hold every channel window.
module pwm_timer_unit #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    import pwm_timer_pkg::*;

    localparam int WIN_SH = LOC_W;
    localparam int IDX_W  = ADDR_W - WIN_SH;

    logic [NUM_CH-1:0]        run_q;
    logic [ADDR_W-1:0]        rel_addr;
    logic                     in_win;
    logic [NUM_CH-1:0]        ch_sel;
    logic [DATA_W-1:0]        ch_rdata [NUM_CH];
    logic [NUM_CH*DATA_W-1:0] ch_count;
    logic [NUM_CH*3-1:0]      ch_pcfg;

    // Offset from the first channel window.
    always_comb begin
        rel_addr = addr - ADDR_W'(CH_BASE);
        in_win   = (addr >= ADDR_W'(CH_BASE));
    end

    // Shared run register: bit n runs channel n.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (wr_en && addr == '0)
            run_q <= wdata[NUM_CH-1:0];
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ch_sel[n] = in_win && (rel_addr[ADDR_W-1:WIN_SH] == IDX_W'(n));

        pwm_channel #(.DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_q[n]),
            .wr_en     (wr_en && ch_sel[n]),
            .loc_addr  (rel_addr[LOC_W-1:0]),
            .wdata     (wdata),
            .rdata     (ch_rdata[n]),
            .pin       (pwm_out[n]),
            .cnt_o     (ch_count[n*DATA_W +: DATA_W]),
            .pin_cfg_o (ch_pcfg[n*3 +: 3])
        );
    end

    // Merge the run register and the selected channel's read data.
    always_comb begin
        rdata = '0;
        if (addr == '0)
            rdata = {{(DATA_W-NUM_CH){1'b0}}, run_q};
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_sel[n])
                rdata = rdata | ch_rdata[n];
        end
    end

endmodule

// File: rtl/pwm_timer_unit_chk.sv
// Property checker for pwm_timer_unit, attached by bind. It watches the bus
// ports, the pins and the run, counter and pin-control state.
module pwm_timer_unit_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [DATA_W-1:0]        wdata,
    input logic [DATA_W-1:0]        rdata,
    input logic [NUM_CH-1:0]        pwm_out,
    input logic [NUM_CH-1:0]        run_q,
    input logic [NUM_CH*DATA_W-1:0] ch_count,
    input logic [NUM_CH*3-1:0]      ch_pcfg
);
    localparam int TOP_ADDR = 16 + 64 * NUM_CH;

    // R1: the run register takes the written channel bits.
    assert_run_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (run_q == $past(wdata[NUM_CH-1:0])));

    // R2: addresses outside every register read zero.
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr >= ADDR_W'(TOP_ADDR)) || (addr != '0 && addr < ADDR_W'(16)))
        |-> (rdata == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_p
        localparam logic [ADDR_W-1:0] CNT_ADR = ADDR_W'(16 + 64 * n + 20);
        localparam logic [ADDR_W-1:0] PIN_ADR = ADDR_W'(16 + 64 * n + 8);

        // R3: a halted counter keeps its value unless the bus loads it.
        assert_halt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[n] && !(wr_en && addr == CNT_ADR))
            |=> $stable(ch_count[n*DATA_W +: DATA_W]));

        // R9: a pin-control write sets the pin to the written initial level.
        assert_pin_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == PIN_ADR) |=> (pwm_out[n] == $past(wdata[2])));

        // R8: with the keep action the pin only moves on a pin-control write.
        assert_keep_static_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_pcfg[n*3 +: 2] == 2'd0 && !(wr_en && addr == PIN_ADR))
            |=> $stable(pwm_out[n]));

        // R10: a counter write loads the written value.
        assert_cnt_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CNT_ADR)
            |=> (ch_count[n*DATA_W +: DATA_W] == $past(wdata)));
    end

endmodule

bind pwm_timer_unit pwm_timer_unit_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pwm_out  (pwm_out),
    .run_q    (run_q),
    .ch_count (ch_count),
    .ch_pcfg  (ch_pcfg)
);

// File: tb/pwm_timer_unit_test.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares them.
module pwm_timer_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [8:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    typedef struct {
        bit          is_pin;
        int          ch;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    pwm_timer_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    localparam logic [5:0] O_CTRL = 6'h00, O_MODE = 6'h04, O_PIN = 6'h08,
                           O_IEN = 6'h0C, O_STS = 6'h10, O_CNT = 6'h14,
                           O_A = 6'h18, O_B = 6'h1C, O_C = 6'h20, O_D = 6'h24;

    function automatic logic [8:0] ra(input int ch, input logic [5:0] ofs);
        return 9'(16 + 64 * ch + int'(ofs));
    endfunction

    // Monitor: pops one expectation per falling edge and compares it.
    initial begin
        forever begin
            item_t it;
            logic [15:0] act;
            wait (sb.size() > 0);
            @(negedge clk);
            it  = sb.pop_front();
            act = it.is_pin ? {15'd0, pwm_out[it.ch]} : rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int k);
        repeat (k) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic exp_rd(input logic [8:0] a, input logic [15:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_pin = 0; it.ch = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); @(posedge clk); #1;
    endtask

    task automatic exp_pin(input int ch, input logic e, input string tag);
        item_t it;
        it.is_pin = 1; it.ch = ch; it.exp = {15'd0, e}; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); @(posedge clk); #1;
    endtask

    // Run one channel for exactly n clock edges after the start write.
    task automatic run_for(input int ch, input int n);
        wr(9'h000, 16'(1 << ch));
        idle(n - 1);
        wr(9'h000, 16'h0000);
    endtask

    task automatic cfg(input int ch, input logic [15:0] ctrl, input logic [15:0] mode,
                       input logic [2:0] pcfg, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] cnt);
        wr(ra(ch, O_CTRL), ctrl);
        wr(ra(ch, O_MODE), mode);
        wr(ra(ch, O_A), a);
        wr(ra(ch, O_B), b);
        wr(ra(ch, O_CNT), cnt);
        wr(ra(ch, O_PIN), {13'd0, pcfg});
    endtask

    function automatic logic [15:0] cw(input int clr, input int edg, input int p);
        return 16'((clr << 5) | (edg << 3) | p);
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] offs [10];
        offs = '{O_CTRL, O_MODE, O_PIN, O_IEN, O_STS, O_CNT, O_A, O_B, O_C, O_D};
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // Reset state (R1, R8)
        exp_rd(9'h000, 16'h0000, "R1 run reset");
        exp_rd(ra(0, O_CTRL), 16'h0000, "R1 ctrl reset");
        exp_rd(ra(3, O_CNT), 16'h0000, "R1 cnt reset");
        exp_pin(2, 1'b0, "R8 pin reset");

        // R1: readback of every register in every channel
        for (int ch = 0; ch < 4; ch++)
            for (int k = 0; k < 10; k++)
                wr(ra(ch, offs[k]), 16'(16'h1000 * ch + 16'h0101 * k + 16'h0040));
        for (int ch = 0; ch < 4; ch++)
            for (int k = 0; k < 10; k++)
                exp_rd(ra(ch, offs[k]), 16'(16'h1000 * ch + 16'h0101 * k + 16'h0040), "R1 readback");
        wr(9'h000, 16'h000A);
        exp_rd(9'h000, 16'h000A, "R1 run readback");
        wr(9'h000, 16'h0000);

        // R2: unmapped addresses
        exp_rd(9'h002, 16'h0000, "R2 low hole");
        exp_rd(9'h00F, 16'h0000, "R2 low hole");
        exp_rd(ra(1, 6'h28), 16'h0000, "R2 window hole");
        exp_rd(ra(2, 6'h3C), 16'h0000, "R2 window hole");
        exp_rd(9'h110, 16'h0000, "R2 above map");
        exp_rd(9'h1FF, 16'h0000, "R2 above map");

        // R4: prescaler rates with rising edge, no clear
        cfg(0, cw(0, 0, 0), 16'h0, 3'b000, 16'h7000, 16'h7000, 16'h0);
        run_for(0, 5);   exp_rd(ra(0, O_CNT), 16'd5, "R4 p0");
        wr(ra(0, O_CTRL), cw(0, 0, 1)); wr(ra(0, O_CNT), 16'h0);
        run_for(0, 7);   exp_rd(ra(0, O_CNT), 16'd1, "R4 p1");
        wr(ra(0, O_CTRL), cw(0, 0, 2)); wr(ra(0, O_CNT), 16'h0);
        run_for(0, 40);  exp_rd(ra(0, O_CNT), 16'd2, "R4 p2");
        wr(ra(0, O_CTRL), cw(0, 0, 3)); wr(ra(0, O_CNT), 16'h0);
        run_for(0, 130); exp_rd(ra(0, O_CNT), 16'd2, "R4 p3");

        // R5: edge selection
        cfg(1, cw(0, 1, 1), 16'h0, 3'b000, 16'h7000, 16'h7000, 16'h0);
        run_for(1, 7); exp_rd(ra(1, O_CNT), 16'd2, "R5 falling");
        wr(ra(1, O_CTRL), cw(0, 2, 1)); wr(ra(1, O_CNT), 16'h0);
        run_for(1, 7); exp_rd(ra(1, O_CNT), 16'd3, "R5 both");
        wr(ra(1, O_CTRL), cw(0, 3, 0)); wr(ra(1, O_CNT), 16'h0);
        run_for(1, 5); exp_rd(ra(1, O_CNT), 16'd5, "R5 both p0");

        // R6: clear sources
        cfg(2, cw(1, 0, 0), 16'h0, 3'b000, 16'd5, 16'd40, 16'h0);
        run_for(2, 14); exp_rd(ra(2, O_CNT), 16'd2, "R6 clear A");
        wr(ra(2, O_CTRL), cw(2, 0, 0)); wr(ra(2, O_B), 16'd4); wr(ra(2, O_CNT), 16'h0);
        run_for(2, 7);  exp_rd(ra(2, O_CNT), 16'd2, "R6 clear B");
        wr(ra(2, O_CTRL), cw(5, 0, 0)); wr(ra(2, O_C), 16'd3); wr(ra(2, O_CNT), 16'h0);
        run_for(2, 10); exp_rd(ra(2, O_CNT), 16'd2, "R6 clear C");
        wr(ra(2, O_CTRL), cw(6, 0, 0)); wr(ra(2, O_D), 16'd7); wr(ra(2, O_CNT), 16'h0);
        run_for(2, 10); exp_rd(ra(2, O_CNT), 16'd2, "R6 clear D");
        wr(ra(2, O_CTRL), cw(3, 0, 0)); wr(ra(2, O_A), 16'd2); wr(ra(2, O_CNT), 16'h0);
        run_for(2, 10); exp_rd(ra(2, O_CNT), 16'd10, "R6 reserved code");
        wr(ra(2, O_CTRL), cw(0, 0, 0)); wr(ra(2, O_CNT), 16'hFFFE);
        run_for(2, 3);  exp_rd(ra(2, O_CNT), 16'd1, "R6 wrap");

        // R7/R8: PWM, initial low, set on A match
        cfg(3, cw(2, 0, 0), 16'h2, 3'b010, 16'd3, 16'd9, 16'h0);
        exp_pin(3, 1'b0, "R9 init low");
        run_for(3, 3); exp_pin(3, 1'b0, "R8 before A");
        run_for(3, 1); exp_pin(3, 1'b1, "R8 set at A");
        exp_rd(ra(3, O_CNT), 16'd4, "R6 count 4");
        run_for(3, 6); exp_pin(3, 1'b0, "R7 restore");
        exp_rd(ra(3, O_CNT), 16'd0, "R6 period end");

        // Inverted polarity, buffer flags in mode (R7, R8, R11)
        wr(ra(3, O_MODE), 16'h0072);
        wr(ra(3, O_PIN), 16'h0005);
        exp_pin(3, 1'b1, "R9 init high");
        run_for(3, 4); exp_pin(3, 1'b0, "R8 clear at A");
        run_for(3, 6); exp_pin(3, 1'b1, "R7 restore high");

        // Normal mode toggle (R8)
        cfg(0, cw(1, 0, 0), 16'h0, 3'b011, 16'd2, 16'd9, 16'h0);
        run_for(0, 3); exp_pin(0, 1'b1, "R8 toggle 1");
        run_for(0, 3); exp_pin(0, 1'b0, "R8 toggle 2");

        // Keep action is static (R8)
        cfg(3, cw(2, 0, 0), 16'h2, 3'b100, 16'd3, 16'd9, 16'h0);
        run_for(3, 20); exp_pin(3, 1'b1, "R8 fixed high");
        wr(ra(3, O_PIN), 16'h0000);
        run_for(3, 7); exp_pin(3, 1'b0, "R8 fixed low");

        // R9 while halted
        wr(ra(2, O_PIN), 16'h0004); exp_pin(2, 1'b1, "R9 halted high");
        wr(ra(2, O_PIN), 16'h0000); exp_pin(2, 1'b0, "R9 halted low");

        // R10: A update while running, counter load
        cfg(3, cw(2, 0, 0), 16'h2, 3'b010, 16'd3, 16'd9, 16'h0);
        wr(9'h000, 16'h0008);
        idle(1);
        wr(ra(3, O_A), 16'd6);
        idle(2);
        wr(9'h000, 16'h0000);
        exp_rd(ra(3, O_CNT), 16'd5, "R10 count");
        exp_pin(3, 1'b0, "R10 old A unused");
        run_for(3, 2); exp_pin(3, 1'b1, "R10 new A");
        wr(ra(3, O_CNT), 16'h1234);
        exp_rd(ra(3, O_CNT), 16'h1234, "R10 load");

        // R11: inert registers
        cfg(1, cw(0, 0, 0), 16'h0070, 3'b000, 16'd2, 16'd3, 16'h0);
        wr(ra(1, O_IEN), 16'hFFFF); wr(ra(1, O_STS), 16'hFFFF);
        run_for(1, 6);
        exp_rd(ra(1, O_CNT), 16'd6, "R11 count unaffected");
        exp_pin(1, 1'b0, "R11 pin unaffected");
        exp_rd(ra(1, O_IEN), 16'hFFFF, "R11 ien readback");

        // R3: independent channels, halted counters hold
        cfg(0, cw(0, 0, 0), 16'h0, 3'b000, 16'h7000, 16'h7000, 16'h0);
        wr(ra(1, O_CNT), 16'h0);
        wr(9'h000, 16'h0001);
        idle(4);
        wr(9'h000, 16'h0003);
        idle(2);
        wr(9'h000, 16'h0000);
        exp_rd(ra(0, O_CNT), 16'd8, "R3 ch0");
        exp_rd(ra(1, O_CNT), 16'd3, "R3 ch1");
        idle(10);
        exp_rd(ra(0, O_CNT), 16'd8, "R3 hold");

        wait (sb.size() == 0);
        idle(2);
        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule